// File: doc/BRIEF.md
# Paged Display Memory Access Controller

This block gives a host controller byte access to a display memory that is organised as 9 pages over 166 columns. Each byte covers eight display lines of one column. The last page holds only one line. The host sends decoded operations: select a page, select a column, write a byte, read a byte, enter or leave read-modify-write mode, reset the address, and choose the column direction. The block keeps the address state and turns each operation into accesses on an internal synchronous memory.

Every data transfer passes through a one-byte holding register. A read hands back the byte that the holder already contains, and at the same time it refills the holder from memory at the current column. So after the address is moved, the first read is a dummy read, and the data arrives from the second read onwards. Read-modify-write mode lets a host read a byte, change it and write it back to the same column. When the host leaves the mode, the column goes back to where the mode started. The direction bit mirrors the column numbering, so a panel that is mounted the other way round still fills from its left edge.

Top module: `disp_ram_ctrl`

## Requirements
- R1: After rst_ni is released, page and column are 0, the direction is normal, modify mode is off, the holder holds 0x00, rdata_o is 0x00 and rvalid_o is 0.
- R2: A READ op (code 4) puts the holder's current byte on rdata_o and pulses rvalid_o for one cycle, one clock after the op. It also refills the holder from memory at the current page and column. So the first read after an address change returns the stale holder byte.
- R3: A WRITE op (code 3) stores arg_i in memory at the current page and column, and it also loads arg_i into the holder.
- R4: Outside modify mode, every READ or WRITE moves the column up by one, and the column stays at 165 once it gets there.
- R5: SET_PAGE (code 1) loads arg_i as the page when arg_i is 8 or less. A larger value is ignored.
- R6: SET_COL (code 2) loads arg_i as the column when arg_i is 165 or less. A larger value is ignored.
- R7: Page 8 stores only bit 0. Bits 7..1 read back as 0, both from memory and from the holder after a write.
- R8: In modify mode (entered with code 5), a READ leaves the column unchanged and a WRITE moves it up by one.
- R9: MOD_END (code 6) puts back the column saved on entry to modify mode and leaves the mode. Outside modify mode it has no effect.
- R10: SET_DIR (code 7) takes its direction from arg_i bit 0. With 0, column c accesses memory column c. With 1, it accesses memory column 165-c.
- R11: ADDR_RST (code 8) sets page and column to 0 and leaves modify mode. It does not change memory contents or the direction.
- R12: READ ops issued on consecutive cycles return consecutive memory bytes with no gap. Code 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Decoded host operation code, one per cycle |
| arg_i | input | 8 | Operand: page, column, write byte or direction bit |
| rdata_o | output | 8 | Byte returned by the most recent READ |
| rvalid_o | output | 1 | One-cycle pulse marking a new rdata_o |

## Verification
The assertions check every cycle that the column never passes 165, that an out-of-range page select leaves the page alone, that the column moves up after a normal access and holds on a modify-mode read, that MOD_END restores the saved column, and that rvalid_o follows only a READ. Only the bench scenarios can show the data path itself. That covers the stale dummy byte, data written on one page and read back through the holder, the single-bit last page, mirrored column mapping, and memory contents that survive an address reset. All of these need known data to be written first and then read back in a defined order.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_SET_PAGE  = 4'd1,
    OP_SET_COL   = 4'd2,
    OP_WRITE     = 4'd3,
    OP_READ      = 4'd4,
    OP_MOD_ENTER = 4'd5,
    OP_MOD_END   = 4'd6,
    OP_SET_DIR   = 4'd7,
    OP_ADDR_RST  = 4'd8
  } op_e;
endpackage

// File: rtl/drc_addr.sv
module drc_addr
  import disp_ram_pkg::*;
#(
  parameter int NCOL  = 166,
  parameter int NPAGE = 9,
  parameter int DW    = 8,
  localparam int CW   = $clog2(NCOL),
  localparam int PW   = $clog2(NPAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [DW-1:0] arg_i,
  output logic [PW-1:0] page_o,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] phys_col_o
);
  localparam logic [CW-1:0] COL_MAX = CW'(NCOL - 1);

  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q, save_q;
  logic          mod_q, rev_q;
  logic          at_max;

  assign at_max = (col_q == COL_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
      save_q <= '0;
      mod_q  <= 1'b0;
      rev_q  <= 1'b0;
    end else begin
      unique case (op_i)
        OP_SET_PAGE:  if (32'(arg_i) < NPAGE) page_q <= PW'(arg_i);
        OP_SET_COL:   if (32'(arg_i) < NCOL)  col_q  <= CW'(arg_i);
        OP_WRITE:     if (!at_max) col_q <= col_q + CW'(1);
        OP_READ:      if (!mod_q && !at_max) col_q <= col_q + CW'(1);
        OP_MOD_ENTER: begin
          mod_q  <= 1'b1;
          save_q <= col_q;
        end
        OP_MOD_END: if (mod_q) begin
          mod_q <= 1'b0;
          col_q <= save_q;
        end
        OP_SET_DIR:  rev_q <= arg_i[0];
        OP_ADDR_RST: begin
          page_q <= '0;
          col_q  <= '0;
          mod_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign page_o     = page_q;
  assign col_o      = col_q;
  assign phys_col_o = rev_q ? (COL_MAX - col_q) : col_q;

  AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_MAX); // R4
  AST_PAGE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SET_PAGE && 32'(arg_i) >= NPAGE) |=> $stable(page_q)); // R5
  AST_ACCESS_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_q && (op_i == OP_READ || op_i == OP_WRITE) && col_q != COL_MAX)
      |=> col_q == $past(col_q) + CW'(1)); // R4
  AST_MOD_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q && op_i == OP_READ) |=> $stable(col_q)); // R8
  AST_MOD_END_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q && op_i == OP_MOD_END) |=> (col_q == $past(save_q) && !mod_q)); // R9
endmodule

// File: rtl/drc_mem.sv
module drc_mem #(
  parameter int NCOL   = 166,
  parameter int NPAGE  = 9,
  parameter int DW     = 8,
  parameter int LAST_W = 1,
  localparam int CW    = $clog2(NCOL),
  localparam int PW    = $clog2(NPAGE)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [PW-1:0] page_i,
  input  logic [CW-1:0] col_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] q [NPAGE];
  logic [PW-1:0] rpage_q;

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    localparam int W = (g == NPAGE - 1) ? LAST_W : DW;
    logic [W-1:0] arr [NCOL];

    always_ff @(posedge clk_i) begin
      if (we_i && page_i == PW'(g)) arr[col_i] <= wdata_i[W-1:0];
      if (re_i && page_i == PW'(g)) q[g] <= DW'(arr[col_i]);
    end
  end

  always_ff @(posedge clk_i) if (re_i) rpage_q <= page_i;

  assign rdata_o = q[rpage_q];
endmodule

// File: rtl/disp_ram_ctrl.sv
module disp_ram_ctrl
  import disp_ram_pkg::*;
#(
  parameter int NCOL = 166,
  parameter int NROW = 65,
  parameter int DW   = 8,
  localparam int NPAGE  = (NROW + DW - 1) / DW,
  localparam int LAST_W = NROW - DW * (NPAGE - 1),
  localparam int CW     = $clog2(NCOL),
  localparam int PW     = $clog2(NPAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] arg_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam logic [DW-1:0] LAST_MASK = DW'((1 << LAST_W) - 1);

  op_e           op;
  logic [PW-1:0] page;
  logic [CW-1:0] col, phys_col;
  logic [DW-1:0] wbyte, mem_rdata;
  logic [DW-1:0] holder_q, rdata_q;
  logic          ld_pend_q, rvalid_q, is_wr, is_rd;

  assign op    = op_e'(op_i);
  assign is_wr = (op == OP_WRITE);
  assign is_rd = (op == OP_READ);
  assign wbyte = (page == PW'(NPAGE - 1)) ? (arg_i & LAST_MASK) : arg_i;

  drc_addr #(.NCOL(NCOL), .NPAGE(NPAGE), .DW(DW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .arg_i      (arg_i),
    .page_o     (page),
    .col_o      (col),
    .phys_col_o (phys_col)
  );

  drc_mem #(.NCOL(NCOL), .NPAGE(NPAGE), .DW(DW), .LAST_W(LAST_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (is_wr),
    .re_i    (is_rd),
    .page_i  (page),
    .col_i   (phys_col),
    .wdata_i (wbyte),
    .rdata_o (mem_rdata)
  );

  // holder refills one cycle after a read; a read in that cycle bypasses it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      holder_q  <= '0;
      rdata_q   <= '0;
      ld_pend_q <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      ld_pend_q <= is_rd;
      rvalid_q  <= is_rd;
      if (is_rd) rdata_q <= ld_pend_q ? mem_rdata : holder_q;
      if (is_wr)          holder_q <= wbyte;
      else if (ld_pend_q) holder_q <= mem_rdata;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(op_i) == 4'(OP_READ)); // R2
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'(OP_READ)) |=> rvalid_o); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 4'(OP_READ)) |=> $stable(rdata_o)); // R2
endmodule

// File: tb/sim_disp_ram_ctrl.sv
`timescale 1ns/1ps
module sim_disp_ram_ctrl;
  import disp_ram_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] arg_i = 8'd0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_ram_ctrl u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .arg_i    (arg_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // {op, arg, check, expected}
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {OP_SET_PAGE, 8'd0,   1'b0, 8'h00},
    {OP_SET_COL,  8'd0,   1'b0, 8'h00},
    {OP_WRITE,    8'h11,  1'b0, 8'h00}, // R3
    {OP_WRITE,    8'h22,  1'b0, 8'h00},
    {OP_WRITE,    8'h33,  1'b0, 8'h00},
    {OP_SET_COL,  8'd0,   1'b0, 8'h00},
    {OP_READ,     8'd0,   1'b1, 8'h33}, // R2 stale byte from write
    {OP_READ,     8'd0,   1'b1, 8'h11}, // R12 back-to-back
    {OP_READ,     8'd0,   1'b1, 8'h22},
    {OP_READ,     8'd0,   1'b1, 8'h33},
    {OP_SET_PAGE, 8'd8,   1'b0, 8'h00},
    {OP_SET_COL,  8'd5,   1'b0, 8'h00},
    {OP_WRITE,    8'hFF,  1'b0, 8'h00},
    {OP_SET_COL,  8'd5,   1'b0, 8'h00},
    {OP_READ,     8'd0,   1'b1, 8'h01}, // R7 holder masked
    {OP_READ,     8'd0,   1'b1, 8'h01}, // R7 memory masked
    {OP_SET_PAGE, 8'd9,   1'b0, 8'h00}, // R5 ignored
    {OP_SET_COL,  8'd5,   1'b0, 8'h00},
    {OP_READ,     8'd0,   1'b0, 8'h00},
    {OP_READ,     8'd0,   1'b1, 8'h01}, // R5 still page 8
    {OP_SET_PAGE, 8'd0,   1'b0, 8'h00},
    {OP_NOP,      8'd0,   1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_op(input op_e op, input logic [7:0] arg);
    op_i  = op;
    arg_i = arg;
    @(negedge clk);
    op_i  = 4'd0;
  endtask

  task automatic rd(input string tag, input logic [7:0] exp, input bit chk);
    op_i = OP_READ;
    @(negedge clk);
    op_i = 4'd0;
    if (chk) begin
      check(tag, rdata_o, exp);
      check({tag, " rvalid"}, {7'd0, rvalid_o}, 8'd1);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i == 6) return "R2";
    if (i >= 7 && i <= 9) return "R12";
    if (i == 14 || i == 15) return "R7";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 rdata", rdata_o, 8'h00);
    check("R1 rvalid", {7'd0, rvalid_o}, 8'h00);
    rd("R1 holder", 8'h00, 1'b1);
    @(negedge clk);
    check("R2 pulse", {7'd0, rvalid_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op_i  = VEC[i][20:17];
      arg_i = VEC[i][16:9];
      @(negedge clk);
      if (VEC[i][8]) check(tag_of(i), rdata_o, VEC[i][7:0]);
    end

    // R4 saturation at 165, R6 ignored column
    do_op(OP_SET_COL, 8'd164);
    do_op(OP_WRITE, 8'hAA);
    do_op(OP_WRITE, 8'hBB);
    do_op(OP_WRITE, 8'hCC);
    do_op(OP_SET_COL, 8'd164);
    rd("R4", 8'h00, 1'b0);
    rd("R4 col164", 8'hAA, 1'b1);
    rd("R4 col165", 8'hCC, 1'b1);
    rd("R4 sat", 8'hCC, 1'b1);
    do_op(OP_SET_COL, 8'd164);
    do_op(OP_SET_COL, 8'd200);
    rd("R6", 8'h00, 1'b0);
    rd("R6 ignored", 8'hAA, 1'b1);

    // R8 / R9 modify mode
    do_op(OP_SET_COL, 8'd1);
    do_op(OP_MOD_ENTER, 8'd0);
    rd("R8", 8'h00, 1'b0);
    rd("R8 no advance", 8'h22, 1'b1);
    do_op(OP_WRITE, 8'h55);
    do_op(OP_MOD_END, 8'd0);
    rd("R9", 8'h00, 1'b0);
    rd("R9 restored", 8'h55, 1'b1);
    rd("R8 write advanced", 8'h33, 1'b1);
    do_op(OP_SET_COL, 8'd0);
    do_op(OP_MOD_END, 8'd0);
    rd("R9", 8'h00, 1'b0);
    rd("R9 end outside mode", 8'h11, 1'b1);

    // R10 mirrored columns
    do_op(OP_SET_DIR, 8'd1);
    do_op(OP_SET_COL, 8'd165);
    rd("R10", 8'h00, 1'b0);
    rd("R10 reversed", 8'h11, 1'b1);
    do_op(OP_SET_COL, 8'd1);
    rd("R10", 8'h00, 1'b0);
    rd("R10 reversed col1", 8'hAA, 1'b1);
    do_op(OP_SET_DIR, 8'd0);

    // R11 address reset keeps memory
    do_op(OP_SET_PAGE, 8'd8);
    do_op(OP_SET_COL, 8'd7);
    do_op(OP_ADDR_RST, 8'd0);
    rd("R11", 8'h00, 1'b0);
    rd("R11 page0 col0", 8'h11, 1'b1);
    rd("R11 col1 kept", 8'h55, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule